// File: doc/BRIEF.md
# Serial Flash Page-Program Splitter

This block takes a write request (a start address and a byte length) plus a byte stream of write data, and turns it into a series of page-program frames for a serial NOR flash. No frame ever crosses a 256-byte page boundary. The first chunk runs only up to the next page boundary. Each later chunk is a full page, or whatever is left if that is less. Every chunk is a separate frame with its own address, and is preceded by two things: a status poll that repeats until the device reports it is idle, and a write-enable frame.

The block talks to a byte-level frame link. It offers one byte at a time with `tx_valid`/`tx_ready` and marks the final byte of a frame with `tx_last`. The link answers each finished frame with one `fr_done` pulse, carrying the last byte it shifted in on `fr_rx`.

Write data only moves while the block is sending the data phase of a program frame. The upstream stream is held off during polling, write-enable and the command and address bytes. A running count of data bytes written is kept. A device that stays busy for too many polls makes the block abort. It then raises a timeout flag and keeps the partial count readable.

The control is a single state machine with these states:
- `S_IDLE`: waits for `start`.
- `S_POLL_OP` → `S_POLL_FILL` → `S_POLL_WAIT`: the status poll.
- `S_WREN` → `S_WREN_WAIT`: the write-enable frame.
- `S_PROG_OP` → `S_PROG_ADDR` → `S_DATA` → `S_PROG_WAIT`: the program frame.

The transitions are:
- `S_IDLE` → `S_POLL_OP` on an accepted, non-empty, in-range start.
- `S_POLL_WAIT` → `S_WREN` on a ready status.
- `S_POLL_WAIT` → `S_POLL_OP` on a busy status below the limit.
- `S_POLL_WAIT` → `S_IDLE` on a busy status at the limit (timeout).
- `S_WREN_WAIT` → `S_PROG_OP` on frame done.
- `S_PROG_ADDR` → `S_DATA` after the third address byte.
- `S_DATA` → `S_PROG_WAIT` on the last byte of the chunk.
- `S_PROG_WAIT` → `S_POLL_OP` when bytes remain.
- `S_PROG_WAIT` → `S_IDLE` when the write is complete.

Top module: `page_prog_splitter`

## Requirements
- R1: After reset the block is idle:
  - `busy`, `done`, both error flags, `wr_ready` and `tx_valid` are low.
  - `bytes_done` is zero.
- R2: A start with zero length produces `done` in the next cycle. No frame is sent, and the count and both error flags read zero.
- R3: A start whose address plus length exceeds the device capacity (`DEV_BYTES`) ends with `done` and `err_range` set, and sends no frame. A range that ends exactly at the capacity is accepted.
- R4: Each chunk is preceded by status-poll frames of two bytes, 0x05 then 0x00. The returned byte's bit 0 means busy, and all other bits are ignored. Polling repeats while bit 0 is 1, and a write-enable frame follows only a poll that returned bit 0 = 0.
- R5: After the ready poll, a single-byte write-enable frame, 0x06, is sent before every program frame.
- R6: A program frame carries, in order:
  - the opcode 0x02;
  - address bits 23:16, then 15:8, then 7:0;
  - the chunk's data bytes, with `tx_last` on the final data byte.
- R7: Chunk sizes and addresses follow the page rule:
  - The first chunk holds min(length, 256 − start mod 256) bytes.
  - Each later chunk holds min(256, bytes remaining).
  - Each chunk's address is the start address plus the bytes already sent, so no chunk crosses a 256-byte page.
- R8: `wr_ready` is high only in the data phase of a program frame. Stream bytes are sent in arrival order, and exactly as many bytes are taken as are written.
- R9: `bytes_done` rises by one per data byte and never counts opcode or address bytes. It equals the length when a normal write finishes, and holds its value while idle.
- R10: If `POLL_MAX` consecutive polls for one chunk all return busy, the block stops with `done` and `err_timeout`. It sends no further frame, and `bytes_done` keeps the count of chunks already programmed.
- R11: `done` is a one-cycle pulse, and `busy` is low in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| start_addr | input | 24 | First byte address of the write |
| length | input | LEN_W | Number of bytes to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Last request rejected as out of range |
| err_timeout | output | 1 | Last request aborted on poll limit |
| bytes_done | output | LEN_W | Data bytes written by the current or last request |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write data accepted this cycle |
| tx_data | output | 8 | Byte offered to the frame link |
| tx_valid | output | 1 | Byte offered |
| tx_last | output | 1 | Byte is the final one of its frame |
| tx_ready | input | 1 | Link accepts the byte |
| fr_done | input | 1 | Link finished the current frame |
| fr_rx | input | 8 | Last byte shifted in during that frame |

## Verification
The poll limit and the ready test are decided by the same `fr_done` response, so a retry, a timeout and a write-enable all compete in one cycle. The bench provokes this with a device model that either becomes busy forever after the first program frame of a request, or is busy from the start. It judges the outcome by four things:
- exactly `POLL_MAX` poll frames follow;
- no write-enable frame follows the last busy poll;
- `err_timeout` is set;
- the count equals the first chunk (or zero).

In the normal runs, busy replies carry random upper status bits, which shows that only bit 0 drives the decision.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int ADDR_W = 24;
    localparam logic [7:0] OP_PROGRAM  = 8'h02;
    localparam logic [7:0] OP_WR_EN    = 8'h06;
    localparam logic [7:0] OP_STATUS   = 8'h05;
    localparam logic [7:0] FILL_BYTE   = 8'h00;
    localparam logic [7:0] BUSY_MASK   = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_OP,
        S_POLL_FILL,
        S_POLL_WAIT,
        S_WREN,
        S_WREN_WAIT,
        S_PROG_OP,
        S_PROG_ADDR,
        S_DATA,
        S_PROG_WAIT
    } pps_state_e;
endpackage

// File: rtl/pps_chunk_calc.sv
module pps_chunk_calc #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 25
) (
    input  logic [PAGE_W-1:0] addr_lo,
    input  logic [LEN_W-1:0]  remain,
    output logic [PAGE_W:0]   chunk
);
    localparam int CHK_W = PAGE_W + 1;

    logic [CHK_W-1:0] room;

    // Bytes left before the next page boundary (a full page when aligned).
    assign room  = CHK_W'(2**PAGE_W) - CHK_W'(addr_lo);
    assign chunk = (remain < LEN_W'(room)) ? remain[PAGE_W:0] : room;
endmodule

// File: rtl/pps_poll_timer.sv
module pps_poll_timer #(
    parameter int POLL_MAX = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(POLL_MAX + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // The busy reply that would be poll number POLL_MAX ends the wait.
    assign expired = tick && (cnt_q == CNT_W'(POLL_MAX - 1));
endmodule

// File: rtl/page_prog_splitter.sv
module page_prog_splitter
    import pps_pkg::*;
#(
    parameter int LEN_W     = 25,
    parameter int PAGE_W    = 8,
    parameter int DEV_BYTES = 2**24,
    parameter int POLL_MAX  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    output logic              busy,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic [LEN_W-1:0]  bytes_done,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              fr_done,
    input  logic [7:0]        fr_rx
);
    localparam int PAGE  = 2**PAGE_W;
    localparam int CHK_W = PAGE_W + 1;
    localparam int SUM_W = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;

    pps_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  count_q;
    logic [CHK_W-1:0]  chunk_q;
    logic [CHK_W-1:0]  chunk_new;
    logic [1:0]        aidx_q;
    logic              done_q, err_range_q, err_to_q;

    logic [SUM_W-1:0]  end_sum;
    logic              past_end;
    logic              status_busy;
    logic              poll_busy;
    logic              poll_expired;
    logic              data_hs;

    assign end_sum     = SUM_W'(start_addr) + SUM_W'(length);
    assign past_end    = end_sum > SUM_W'(DEV_BYTES);
    assign status_busy = |(fr_rx & BUSY_MASK);
    assign poll_busy   = (state_q == S_POLL_WAIT) && fr_done && status_busy;
    assign data_hs     = (state_q == S_DATA) && wr_valid && tx_ready;

    pps_chunk_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) i_chunk (
        .addr_lo (addr_q[PAGE_W-1:0]),
        .remain  (remain_q),
        .chunk   (chunk_new)
    );

    pps_poll_timer #(.POLL_MAX(POLL_MAX)) i_poll_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == S_IDLE) || (state_q == S_WREN)),
        .tick    (poll_busy),
        .expired (poll_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (start && (length != '0) && !past_end) state_d = S_POLL_OP;
            S_POLL_OP:   if (tx_ready) state_d = S_POLL_FILL;
            S_POLL_FILL: if (tx_ready) state_d = S_POLL_WAIT;
            S_POLL_WAIT:
                if (fr_done) begin
                    if (!status_busy)     state_d = S_WREN;
                    else if (poll_expired) state_d = S_IDLE;
                    else                   state_d = S_POLL_OP;
                end
            S_WREN:      if (tx_ready) state_d = S_WREN_WAIT;
            S_WREN_WAIT: if (fr_done)  state_d = S_PROG_OP;
            S_PROG_OP:   if (tx_ready) state_d = S_PROG_ADDR;
            S_PROG_ADDR: if (tx_ready && (aidx_q == 2'd2)) state_d = S_DATA;
            S_DATA:      if (data_hs && (chunk_q == CHK_W'(1))) state_d = S_PROG_WAIT;
            S_PROG_WAIT:
                if (fr_done) state_d = (remain_q == '0) ? S_IDLE : S_POLL_OP;
            default:     state_d = S_IDLE;
        endcase
    end

    // Request and chunk bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            remain_q    <= '0;
            count_q     <= '0;
            chunk_q     <= '0;
            aidx_q      <= '0;
            done_q      <= 1'b0;
            err_range_q <= 1'b0;
            err_to_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE:
                    if (start) begin
                        err_range_q <= 1'b0;
                        err_to_q    <= 1'b0;
                        count_q     <= '0;
                        addr_q      <= start_addr;
                        remain_q    <= length;
                        if (length == '0) begin
                            done_q <= 1'b1;
                        end else if (past_end) begin
                            done_q      <= 1'b1;
                            err_range_q <= 1'b1;
                        end
                    end
                S_POLL_WAIT:
                    if (poll_busy && poll_expired) begin
                        err_to_q <= 1'b1;
                        done_q   <= 1'b1;
                    end
                S_WREN_WAIT:
                    if (fr_done) begin
                        chunk_q <= chunk_new;
                        aidx_q  <= '0;
                    end
                S_PROG_ADDR:
                    if (tx_ready) aidx_q <= aidx_q + 2'd1;
                S_DATA:
                    if (data_hs) begin
                        addr_q   <= addr_q + ADDR_W'(1);
                        remain_q <= remain_q - LEN_W'(1);
                        count_q  <= count_q + LEN_W'(1);
                        chunk_q  <= chunk_q - CHK_W'(1);
                    end
                S_PROG_WAIT:
                    if (fr_done && (remain_q == '0)) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_data  = FILL_BYTE;
        wr_ready = 1'b0;
        unique case (state_q)
            S_POLL_OP:   begin tx_valid = 1'b1; tx_data = OP_STATUS; end
            S_POLL_FILL: begin tx_valid = 1'b1; tx_last = 1'b1; end
            S_WREN:      begin tx_valid = 1'b1; tx_last = 1'b1; tx_data = OP_WR_EN; end
            S_PROG_OP:   begin tx_valid = 1'b1; tx_data = OP_PROGRAM; end
            S_PROG_ADDR: begin
                tx_valid = 1'b1;
                unique case (aidx_q)
                    2'd0:    tx_data = addr_q[23:16];
                    2'd1:    tx_data = addr_q[15:8];
                    default: tx_data = addr_q[7:0];
                endcase
            end
            S_DATA: begin
                tx_valid = wr_valid;
                tx_data  = wr_data;
                tx_last  = (chunk_q == CHK_W'(1));
                wr_ready = tx_ready;
            end
            default: ;
        endcase
    end

    assign busy        = (state_q != S_IDLE);
    assign done        = done_q;
    assign err_range   = err_range_q;
    assign err_timeout = err_to_q;
    assign bytes_done  = count_q;

    // R7: the data phase never runs past the end of the current page
    p_page_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA) |->
            ((chunk_q != '0) &&
             ((PAGE_W+2)'(addr_q[PAGE_W-1:0]) + (PAGE_W+2)'(chunk_q) <= (PAGE_W+2)'(PAGE))));

    // R8: upstream is stalled outside the data phase
    p_stream_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_DATA) |-> !wr_ready);

    // R9: one count step per accepted data byte
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (bytes_done == $past(bytes_done) + LEN_W'(1)));

    // R9: count holds while idle with no new request
    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(bytes_done));

    // R2: empty request finishes in the next cycle without error
    p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && start && (length == '0)) |=> (done && !err_range && !busy));

    // R11: done is a single-cycle pulse, never while busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R10: a timeout leaves the block idle
    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (!busy && done));
endmodule

// File: tb/test_page_prog_splitter.sv
module test_page_prog_splitter;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LEN_W = 25;
    localparam int DEV   = 4096;
    localparam int PMAX  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [23:0]       start_addr = '0;
    logic [LEN_W-1:0]  length = '0;
    logic              busy, done, err_range, err_timeout;
    logic [LEN_W-1:0]  bytes_done;
    logic [7:0]        wr_data = '0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [7:0]        tx_data;
    logic              tx_valid, tx_last;
    logic              tx_ready = 1'b0;
    logic              fr_done = 1'b0;
    logic [7:0]        fr_rx = '0;

    always #2 clk = ~clk;

    page_prog_splitter #(.LEN_W(LEN_W), .PAGE_W(8), .DEV_BYTES(DEV), .POLL_MAX(PMAX))
    i_page_prog_splitter (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
        .busy(busy), .done(done), .err_range(err_range), .err_timeout(err_timeout),
        .bytes_done(bytes_done), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .fr_done(fr_done), .fr_rx(fr_rx)
    );

    int checks = 0;
    int fails  = 0;

    // device / link model state
    int         busy_polls = 0;
    bit         stuck = 0;
    bit         stuck_next = 0;
    int         polls_since_stuck = 0;
    bit         last_ready = 0;
    bit         fr_pend = 0;
    int         fr_delay = 0;
    logic [7:0] fr_val = '0;
    logic [7:0] cur_frame[$];
    logic [7:0] exp_bytes[$];
    int         exp_lens[$];
    int         frames_seen = 0;

    // stream source
    int src_len = 0;
    int src_idx = 0;
    bit src_on = 0;
    int op_seed = 0;

    bit               done_seen = 0;
    logic [LEN_W-1:0] cnt_at_done = '0;
    logic             er_at_done = 0;
    logic             et_at_done = 0;
    int               cyc = 0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + op_seed) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Build expected non-status frames; returns total data bytes expected.
    function automatic int build_expected(int addr, int len, int max_chunks);
        int sent = 0;
        int nchunk = 0;
        while (sent < len && nchunk < max_chunks) begin
            int cur = addr + sent;
            int room = 256 - (cur % 256);
            int c = (len - sent < room) ? (len - sent) : room;
            exp_lens.push_back(1);
            exp_bytes.push_back(8'h06);
            exp_lens.push_back(4 + c);
            exp_bytes.push_back(8'h02);
            exp_bytes.push_back(8'((cur >> 16) & 255));
            exp_bytes.push_back(8'((cur >> 8) & 255));
            exp_bytes.push_back(8'(cur & 255));
            for (int k = 0; k < c; k++) exp_bytes.push_back(pat(sent + k));
            sent += c;
            nchunk++;
        end
        return sent;
    endfunction

    task automatic handle_frame();
        logic [31:0] r;
        frames_seen++;
        r = $urandom;
        if (cur_frame[0] == 8'h05) begin
            bit wip;
            chk((cur_frame.size() == 2) && (cur_frame[1] == 8'h00), "R4", "status poll frame shape",
                cur_frame.size(), 2);
            wip = stuck || (busy_polls > 0);
            if (!stuck && busy_polls > 0) busy_polls--;
            if (stuck) polls_since_stuck++;
            last_ready = !wip;
            fr_val = {r[7:1], wip};
        end else begin
            if (cur_frame[0] == 8'h06) begin
                chk(last_ready, "R4", "write-enable only after ready poll", int'(last_ready), 1);
                last_ready = 0;
            end
            if (cur_frame[0] == 8'h02) begin
                if (stuck_next) begin stuck = 1; stuck_next = 0; end
                else busy_polls = $urandom % 3;
            end
            if (exp_lens.size() == 0) begin
                chk(0, "R7", "unexpected frame, first byte", int'(cur_frame[0]), -1);
            end else begin
                int n = exp_lens.pop_front();
                logic [7:0] e[$];
                for (int k = 0; k < n; k++) e.push_back(exp_bytes.pop_front());
                if (cur_frame.size() != n) begin
                    chk(0, "R7", "frame length", cur_frame.size(), n);
                end else begin
                    int bad = -1;
                    for (int k = 0; k < n; k++) if (bad < 0 && cur_frame[k] != e[k]) bad = k;
                    if (bad < 0)            chk(1, "R6", "frame content", 0, 0);
                    else if (n == 1)        chk(0, "R5", "write-enable byte", cur_frame[0], e[0]);
                    else if (bad < 4)       chk(0, "R6", "opcode/address byte", cur_frame[bad], e[bad]);
                    else                    chk(0, "R8", "data byte order", cur_frame[bad], e[bad]);
                end
            end
            fr_val = r[7:0];
        end
        fr_pend = 1;
        fr_delay = $urandom % 3;
    endtask

    // Link and source model: drive at negedge, observe 1 ns later.
    always @(negedge clk) begin
        if (rst_n) begin
            tx_ready = ($urandom % 4) != 0;
            fr_done  = 1'b0;
            if (fr_pend) begin
                if (fr_delay == 0) begin
                    fr_done = 1'b1;
                    fr_rx   = fr_val;
                    fr_pend = 0;
                end else begin
                    fr_delay--;
                end
            end
            wr_valid = src_on && (src_idx < src_len) && (($urandom % 4) != 0);
            wr_data  = pat(src_idx);
            #1;
            if (done) begin
                done_seen   = 1;
                cnt_at_done = bytes_done;
                er_at_done  = err_range;
                et_at_done  = err_timeout;
            end
            if (wr_valid && wr_ready) src_idx++;
            if (tx_valid && tx_ready) begin
                cur_frame.push_back(tx_data);
                if (tx_last) begin
                    handle_frame();
                    cur_frame.delete();
                end
            end
        end
    end

    // mode: 0 normal, 1 stuck after first program frame, 2 stuck from start, 3 range reject
    task automatic run_op(int addr, int len, int mode);
        int exp_cnt;
        int f0;
        int cycles;
        exp_lens.delete();
        exp_bytes.delete();
        op_seed = $urandom % 256;
        if (mode == 3 || len == 0)  exp_cnt = 0;
        else if (mode == 2)         exp_cnt = 0;
        else if (mode == 1)         exp_cnt = build_expected(addr, len, 1);
        else                        exp_cnt = build_expected(addr, len, 1 << 20);
        @(posedge clk); #1;
        src_len = len; src_idx = 0; src_on = 1; done_seen = 0;
        polls_since_stuck = 0;
        stuck = (mode == 2);
        stuck_next = (mode == 1);
        f0 = frames_seen;
        start = 1'b1; start_addr = 24'(addr); length = LEN_W'(len);
        @(posedge clk); #1;
        start = 1'b0;
        cycles = 0;
        while (!done_seen) begin @(posedge clk); cycles++; end
        if (len == 0) begin
            chk(cycles <= 1, "R2", "zero length done latency", cycles, 1);
            chk(frames_seen == f0, "R2", "frames on zero length", frames_seen - f0, 0);
        end
        if (mode == 3)
            chk(frames_seen == f0, "R3", "frames on range reject", frames_seen - f0, 0);
        chk(er_at_done == (mode == 3), "R3", "range flag", int'(er_at_done), int'(mode == 3));
        chk(et_at_done == (mode == 1 || mode == 2), "R10", "timeout flag", int'(et_at_done),
            int'(mode == 1 || mode == 2));
        chk(int'(cnt_at_done) == exp_cnt, (mode == 1 || mode == 2) ? "R10" : "R9", "byte count",
            int'(cnt_at_done), exp_cnt);
        chk(exp_lens.size() == 0, "R7", "missing frames", exp_lens.size(), 0);
        chk(src_idx == exp_cnt, "R8", "stream bytes taken", src_idx, exp_cnt);
        if (mode == 1 || mode == 2)
            chk(polls_since_stuck == PMAX, "R10", "busy polls before abort", polls_since_stuck, PMAX);
        @(posedge clk); #1;
        chk(!busy && !wr_ready && !tx_valid && !done, "R11", "idle after done pulse",
            int'({busy, wr_ready, tx_valid, done}), 0);
        chk(bytes_done == cnt_at_done, "R9", "count held while idle", int'(bytes_done),
            int'(cnt_at_done));
        src_on = 0;
        stuck = 0;
        stuck_next = 0;
        repeat (3) @(posedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog (R11 completion): actual hang expected done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        chk(!busy && !done && !err_range && !err_timeout && !wr_ready && !tx_valid && bytes_done == '0,
            "R1", "reset state", int'({busy, done, err_range, err_timeout, wr_ready, tx_valid}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!busy && !wr_ready && !tx_valid, "R1", "idle after reset release",
            int'({busy, wr_ready, tx_valid}), 0);

        run_op(0, 0, 0);          // R2
        run_op(4000, 200, 3);     // R3 past end
        run_op(3840, 256, 0);     // R3 exact end accepted
        run_op(256, 256, 0);      // R7 aligned full page
        run_op(240, 16, 0);       // R7 exact fit to boundary
        run_op(240, 17, 0);       // R7 split 16 + 1
        run_op(128, 513, 0);      // R7 partial + full pages + tail
        run_op(255, 1, 0);        // R7 last byte of a page
        run_op(100, 300, 1);      // R10 stuck after first chunk
        run_op(512, 40, 2);       // R10 stuck before any chunk
        for (int n = 0; n < 10; n++) begin
            int len  = 1 + ($urandom % 600);
            int addr = $urandom % (DEV - len + 1);
            run_op(addr, len, 0);
        end
        summary();
        $finish;
    end
endmodule